// File: doc/BRIEF.md
# Privileged Control Register File

A bank of privileged processor control registers, addressed by a 5-bit index through one write port and one read port. Each write passes through the rule for the register it targets. Most registers keep only the bits they implement, under a fixed mask. Two exception registers clear themselves on any write. Read-only indices reject the write with a fault. Three invalidate-control indices do not store readable state; they raise a one-cycle strobe for the translation logic next to this block. One index holds a cycle-count register. Its upper half is stored, and its lower half is taken live from a free-running counter at read time.

A speculation input marks writes that come from instructions which may still be squashed. Such writes are dropped without a fault, and no strobe fires for them. Writes are plain control: they are always accepted, and a done/fault pair reports them one cycle later. Reads are a stream. The requester holds `rd_valid` until `rd_ready` is seen. The response sits in a single output register and stays stable while `rsp_ready` is low. `rd_ready` is high only when that register is empty or is being drained in the same cycle.

Index map (5-bit): 0..3 scratch (all 64 bits), 4 trap request, 5 trap enable, 6 priority level, 7 software interrupt request, 8 and 9 mode registers, 10 exception address, 11 exception summary, 12 exception mask, 13 interrupt ID, 14 memory-management status, 15 page-entry temporary, 16 cache mode, 17 miss-queue mode, 18 instruction address-space ID, 19 cache test control, 20 cycle count, 21 invalidate-all, 22 invalidate-process, 23 invalidate-single. Indices 24..31 are undefined.

Top module: `pcr_file`

## Requirements
- R1: After reset every register reads as zero, and no strobe, `wr_done` or response is asserted.
- R2: A write to a scratch index (0..3) or to the cycle-count index (20) stores all 64 data bits.
- R3: A write stores data AND mask for each masked register: 0xf for indices 4 and 5, 0x1f for 6, 0x7fff0 for 7, 0x18 for 8 and 9, 0x3f for 16 and 17, 0x7f0 for 18, and 0x1ffb for 19.
- R4: A write to the exception address (index 10) stores the data with bit 1 forced to zero.
- R5: Any write to index 11 or 12 leaves that register at zero, whatever the data.
- R6: A write to a read-only index (13, 14, 15) or to an undefined index (24..31) sets `wr_fault` and changes nothing; read-only indices read as zero without a fault.
- R7: A read of a write-only index (21..23) or of an undefined index returns `rsp_fault`=1 with data zero; every other read returns `rsp_fault`=0.
- R8: A read of index 20 returns bits 63:32 from the stored value and bits 31:0 from a counter that resets to zero and advances by one on every clock edge after reset is released; the counter value is taken in the cycle the read is accepted.
- R9: While `spec` is high, a write changes no register, reports `wr_done`=1 with `wr_fault`=0, and raises no strobe.
- R10: A write to index 21, 22 or 23 pulses `inv_all`, `inv_proc` or `inv_one`, respectively, for exactly one cycle, in the cycle after the write; for `inv_one`, `inv_addr` carries the written data.
- R11: A read accepted at a clock edge presents its response from that edge onward; while `rsp_valid` is high and `rsp_ready` is low, the response holds its value and `rd_ready` is low.
- R12: `wr_done` and `wr_fault` appear in the cycle after the write is presented; a read that is accepted in the same cycle as a write to the same index returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec | input | 1 | Write is speculative; drop it |
| wr_valid | input | 1 | Write request this cycle |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data |
| wr_done | output | 1 | Write processed (one cycle later) |
| wr_fault | output | 1 | Write was rejected |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high with rd_valid |
| rd_idx | input | 5 | Read register index |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 64 | Read data |
| rsp_fault | output | 1 | Read was rejected |
| inv_all | output | 1 | Invalidate-all strobe |
| inv_proc | output | 1 | Invalidate-process strobe |
| inv_one | output | 1 | Invalidate-single strobe |
| inv_addr | output | 64 | Address for the invalidate-single strobe |

## Verification
The bench uses the default index width of 5, so all 32 indices are reachable. That includes every rule class and the full undefined range at the top of the map. The counter half is 32 bits wide, so the live low half of the cycle register can be predicted exactly by counting clock edges from reset. With these values, the random phase reaches every mask, the clear-on-write registers, the fault paths and the speculative drops. The directed phase holds the response register under back-pressure while a second read is pending.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int PCR_DW  = 64;
  localparam int PCR_IW  = 5;
  localparam int PCR_NUM = 1 << PCR_IW;

  typedef enum logic [2:0] {
    PK_RW, PK_CLR, PK_RO, PK_INV_ALL, PK_INV_PROC, PK_INV_ONE, PK_UNDEF
  } pcr_kind_e;

  localparam logic [PCR_IW-1:0] IX_CYCLE = 5'd20;

  function automatic pcr_kind_e kind_of(input logic [PCR_IW-1:0] idx);
    case (idx)
      5'd11, 5'd12:        return PK_CLR;
      5'd13, 5'd14, 5'd15: return PK_RO;
      5'd21:               return PK_INV_ALL;
      5'd22:               return PK_INV_PROC;
      5'd23:               return PK_INV_ONE;
      default:             return (idx <= 5'd20) ? PK_RW : PK_UNDEF;
    endcase
  endfunction

  function automatic logic [PCR_DW-1:0] mask_of(input logic [PCR_IW-1:0] idx);
    case (idx)
      5'd4, 5'd5:   return 64'hf;
      5'd6:         return 64'h1f;
      5'd7:         return 64'h7fff0;
      5'd8, 5'd9:   return 64'h18;
      5'd10:        return ~64'h2;
      5'd16, 5'd17: return 64'h3f;
      5'd18:        return 64'h7f0;
      5'd19:        return 64'h1ffb;
      default:      return '1;
    endcase
  endfunction
endpackage

// File: rtl/pcr_cycle_ctr.sv
module pcr_cycle_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/pcr_wr_filter.sv
module pcr_wr_filter
  import pcr_pkg::*;
(
  input  logic              valid,
  input  logic              spec,
  input  logic [PCR_IW-1:0] idx,
  input  logic [PCR_DW-1:0] data,
  output logic              we,
  output logic [PCR_DW-1:0] wval,
  output logic              fault,
  output logic              s_all,
  output logic              s_proc,
  output logic              s_one
);
  pcr_kind_e k;
  logic      live;

  always_comb begin
    k      = kind_of(idx);
    live   = valid && !spec;
    we     = live && (k == PK_RW || k == PK_CLR);
    wval   = (k == PK_CLR) ? '0 : (data & mask_of(idx));
    fault  = live && (k == PK_RO || k == PK_UNDEF);
    s_all  = live && (k == PK_INV_ALL);
    s_proc = live && (k == PK_INV_PROC);
    s_one  = live && (k == PK_INV_ONE);
  end
endmodule

// File: rtl/pcr_bank.sv
module pcr_bank
  import pcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PCR_IW-1:0] widx,
  input  logic [PCR_DW-1:0] wval,
  output logic [PCR_DW-1:0] regs [PCR_NUM]
);
  for (genvar g = 0; g < PCR_NUM; g++) begin : g_reg
    localparam pcr_kind_e K = kind_of(PCR_IW'(g));
    if (K == PK_RW || K == PK_CLR) begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)                           regs[g] <= '0;
        else if (we && widx == PCR_IW'(g))    regs[g] <= wval;
      end
      if (K == PK_CLR) begin : g_clr_chk
        a_r5_clear_stays: assert property (@(posedge clk) disable iff (!rst_n)
          regs[g] == '0);
      end
    end else begin : g_none
      assign regs[g] = '0;
    end
  end
endmodule

// File: rtl/pcr_rd_port.sv
module pcr_rd_port
  import pcr_pkg::*;
#(
  parameter int LOW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [PCR_IW-1:0] rd_idx,
  input  logic [PCR_DW-1:0] regs [PCR_NUM],
  input  logic [LOW_W-1:0]  cnt,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PCR_DW-1:0] rsp_data,
  output logic              rsp_fault
);
  pcr_kind_e         k;
  logic              bad;
  logic [PCR_DW-1:0] val;

  assign rd_ready = !rsp_valid || rsp_ready;

  always_comb begin
    k   = kind_of(rd_idx);
    bad = (k == PK_INV_ALL) || (k == PK_INV_PROC) || (k == PK_INV_ONE) || (k == PK_UNDEF);
    val = regs[rd_idx];
    if (rd_idx == IX_CYCLE) val[LOW_W-1:0] = cnt;
    if (bad) val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_fault <= 1'b0;
    end else if (rd_ready) begin
      rsp_valid <= rd_valid;
      if (rd_valid) begin
        rsp_data  <= val;
        rsp_fault <= bad;
      end
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_fault));
  a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_data == '0);
endmodule

// File: rtl/pcr_file.sv
module pcr_file
  import pcr_pkg::*;
#(
  parameter int LOW_W = PCR_DW / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spec,
  input  logic              wr_valid,
  input  logic [PCR_IW-1:0] wr_idx,
  input  logic [PCR_DW-1:0] wr_data,
  output logic              wr_done,
  output logic              wr_fault,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [PCR_IW-1:0] rd_idx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PCR_DW-1:0] rsp_data,
  output logic              rsp_fault,
  output logic              inv_all,
  output logic              inv_proc,
  output logic              inv_one,
  output logic [PCR_DW-1:0] inv_addr
);
  logic              we, f_c, sa_c, sp_c, so_c;
  logic [PCR_DW-1:0] wval;
  logic [PCR_DW-1:0] regs [PCR_NUM];
  logic [LOW_W-1:0]  cnt;

  pcr_wr_filter u_wf (
    .valid(wr_valid), .spec(spec), .idx(wr_idx), .data(wr_data),
    .we(we), .wval(wval), .fault(f_c),
    .s_all(sa_c), .s_proc(sp_c), .s_one(so_c)
  );

  pcr_bank u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(wr_idx), .wval(wval), .regs(regs)
  );

  pcr_cycle_ctr #(.W(LOW_W)) u_ctr (.clk(clk), .rst_n(rst_n), .cnt(cnt));

  pcr_rd_port #(.LOW_W(LOW_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_idx(rd_idx), .regs(regs), .cnt(cnt), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_fault(rsp_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_done  <= 1'b0;
      wr_fault <= 1'b0;
      inv_all  <= 1'b0;
      inv_proc <= 1'b0;
      inv_one  <= 1'b0;
      inv_addr <= '0;
    end else begin
      wr_done  <= wr_valid;
      wr_fault <= f_c;
      inv_all  <= sa_c;
      inv_proc <= sp_c;
      inv_one  <= so_c;
      if (so_c) inv_addr <= wr_data;
    end
  end

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inv_all, inv_proc, inv_one}));
  a_r9_spec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && spec |=> wr_done && !wr_fault && !inv_all && !inv_proc && !inv_one);
  a_r12_fault_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> wr_done);
endmodule

// File: tb/pcr_file_bench.sv
`timescale 1ns/1ps
module pcr_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spec = 1'b0, wr_valid = 1'b0, rd_valid = 1'b0, rsp_ready = 1'b1;
  logic [4:0]  wr_idx = '0, rd_idx = '0;
  logic [63:0] wr_data = '0;
  logic        wr_done, wr_fault, rd_ready, rsp_valid, rsp_fault;
  logic        inv_all, inv_proc, inv_one;
  logic [63:0] rsp_data, inv_addr;

  always #2 clk = ~clk;

  pcr_file u_pcr_file (
    .clk(clk), .rst_n(rst_n), .spec(spec), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_done(wr_done), .wr_fault(wr_fault), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_idx(rd_idx), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_fault(rsp_fault), .inv_all(inv_all), .inv_proc(inv_proc),
    .inv_one(inv_one), .inv_addr(inv_addr)
  );

  int          n_chk = 0, n_bad = 0;
  logic [63:0] shadow [32];
  logic [31:0] cyc = '0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1;
  end

  // 0 plain/masked, 1 clear, 2 read-only, 3 inv all, 4 inv proc, 5 inv one, 6 undefined
  function automatic int cls(input int i);
    if (i == 11 || i == 12) return 1;
    if (i >= 13 && i <= 15) return 2;
    if (i == 21) return 3;
    if (i == 22) return 4;
    if (i == 23) return 5;
    if (i > 23) return 6;
    return 0;
  endfunction

  function automatic logic [63:0] msk(input int i);
    case (i)
      4, 5:   return 64'hf;
      6:      return 64'h1f;
      7:      return 64'h7fff0;
      8, 9:   return 64'h18;
      10:     return 64'hffff_ffff_ffff_fffd;
      16, 17: return 64'h3f;
      18:     return 64'h7f0;
      19:     return 64'h1ffb;
      default: return '1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int i, input logic [63:0] d, input bit sp, input string tag);
    int  c;
    bit  ef;
    logic [2:0] es;
    c = cls(i);
    @(negedge clk);
    spec = sp; wr_valid = 1'b1; wr_idx = 5'(i); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; spec = 1'b0;
    ef = !sp && (c == 2 || c == 6);
    es = sp ? 3'b000 : {c == 3, c == 4, c == 5};
    chk(wr_done == 1'b1, {tag, " done"}, 64'(wr_done), 64'd1);
    chk(wr_fault == ef, {tag, " fault"}, 64'(wr_fault), 64'(ef));
    chk({inv_all, inv_proc, inv_one} == es, {tag, " R10 strobes"}, 64'({inv_all, inv_proc, inv_one}), 64'(es));
    if (es[0]) chk(inv_addr == d, {tag, " R10 addr"}, inv_addr, d);
    if (!sp) begin
      if (c == 0) shadow[i] = d & msk(i);
      if (c == 1) shadow[i] = '0;
    end
  endtask

  task automatic do_read(input int i, input string tag);
    logic [63:0] e;
    bit          ef;
    @(negedge clk);
    rd_valid = 1'b1; rd_idx = 5'(i);
    ef = (cls(i) >= 3);
    e  = ef ? 64'd0 : shadow[i];
    if (i == 20) e[31:0] = cyc;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " R11 valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_fault == ef, {tag, " R7 fault"}, 64'(rsp_fault), 64'(ef));
    chk(rsp_data == e, {tag, " data"}, rsp_data, e);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] v0, v1;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 32; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({wr_done, rsp_valid, inv_all, inv_proc, inv_one} == 5'b0, "R1 idle outputs",
        64'({wr_done, rsp_valid, inv_all, inv_proc, inv_one}), 64'd0);
    for (int i = 0; i < 32; i++) if (i != 20) do_read(i, "R1 reset sweep");

    do_write(2, 64'hdead_beef_0123_4567, 1'b0, "R2 scratch");
    do_read(2, "R2 scratch");
    for (int i = 4; i <= 19; i++) if (cls(i) == 0) begin
      do_write(i, '1, 1'b0, "R3 mask");
      do_read(i, "R3 mask");
    end
    do_write(10, 64'h0000_0000_0000_0007, 1'b0, "R4 exc addr");
    do_read(10, "R4 exc addr");
    do_write(11, '1, 1'b0, "R5 clear");
    do_read(11, "R5 clear");
    do_write(12, 64'h55, 1'b0, "R5 clear");
    do_read(12, "R5 clear");
    do_write(14, '1, 1'b0, "R6 read-only");
    do_read(14, "R6 read-only");
    do_write(27, '1, 1'b0, "R6 undefined");
    do_read(27, "R7 undefined");
    do_read(22, "R7 write-only");
    do_write(20, 64'h1234_5678_ffff_ffff, 1'b0, "R2 cycle store");
    do_read(20, "R8 cycle merge");
    repeat (5) @(negedge clk);
    do_read(20, "R8 cycle advance");
    do_write(3, 64'h77, 1'b0, "R9 setup");
    do_write(3, 64'h99, 1'b1, "R9 spec write");
    do_read(3, "R9 unchanged");
    do_write(23, 64'h4000, 1'b1, "R9 spec strobe");
    do_write(23, 64'habc0, 1'b0, "R10 inv one");
    @(negedge clk);
    chk(inv_one == 1'b0, "R10 single pulse", 64'(inv_one), 64'd0);
    do_write(21, 64'h1, 1'b0, "R10 inv all");
    do_write(22, 64'h2, 1'b0, "R10 inv proc");

    // R12: read and write to the same index in one cycle
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = 5'd1; wr_data = 64'hf00d;
    rd_valid = 1'b1; rd_idx = 5'd1;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    chk(rsp_data == shadow[1], "R12 old value", rsp_data, shadow[1]);
    shadow[1] = 64'hf00d;
    do_read(1, "R12 new value");

    // R11 back-pressure
    v0 = shadow[2]; v1 = shadow[3];
    @(negedge clk);
    rsp_ready = 1'b0; rd_valid = 1'b1; rd_idx = 5'd2;
    @(negedge clk);
    rd_idx = 5'd3;
    chk(rd_ready == 1'b0, "R11 not ready", 64'(rd_ready), 64'd0);
    @(negedge clk);
    chk(rsp_valid && rsp_data == v0, "R11 held", rsp_data, v0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rsp_valid && rsp_data == v1, "R11 next", rsp_data, v1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 drained", 64'(rsp_valid), 64'd0);

    for (int n = 0; n < 400; n++) begin
      int i;
      logic [63:0] d;
      i = $urandom_range(0, 31);
      d = {$urandom(), $urandom()};
      if ($urandom_range(0, 1) == 0) do_write(i, d, ($urandom_range(0, 7) == 0), "R3 random write");
      else do_read(i, "R7 random read");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule